// File: doc/BRIEF.md
# Unit Timer with Position Count Capture

This block runs a free-running interval timer next to a quadrature position counter. It also holds the snapshot logic that freezes the position count for software. When the timer is enabled it counts module clocks. Once it reaches a programmable period it restarts from zero and raises a sticky event flag. Depending on the control options, that match also snapshots the live position count into a hold register, or asks the position counter to clear itself.

Software can also take a snapshot on demand. It sets a hold-request bit, which captures the count and then clears itself. Any of four external timer flags can set the same bit on its rising edge, provided that flag is enabled. The timer can be told to follow the position counter's index reset, so that both restart together.

All configuration arrives through a small write port with a two-bit register select. Select 0 is control. In it, bit 0 enables the timer, bit 1 selects capture on match, bit 2 selects position reset on match, bit 3 selects follow-index and bit 4 is index reload enable. Bits 5 to 8 enable external flags 0 to 3. Select 1 is the period. Select 2 is the timer count. Select 3 is the command word: bit 0 writes the hold request and bit 1 clears the event flag.

Top module: `unit_timer_capture`

## Requirements
- R1: After reset, timer_count, hold_value, hold_busy, event_flag and pos_reset_req are all zero.
- R2: While the timer is enabled, timer_count rises by one each clock. In a cycle where it equals the period it becomes zero at the next edge.
- R3: A match sets event_flag at the next edge. The flag stays set until a select-3 write with bit 1 set. If a clear and a match fall in the same cycle, the flag stays set.
- R4: A select-2 write loads timer_count only while the timer is disabled. While the timer is enabled such a write has no effect.
- R5: With capture-on-match (control bit 1) set, a match copies that cycle's pos_count into hold_value.
- R6: With reset-on-match (control bit 2) set, pos_reset_req is high for exactly the one cycle after a match, and low otherwise.
- R7: With both index reload (bit 4) and follow-index (bit 3) set, idx_reset_evt zeroes timer_count at the next edge. If either bit is clear, idx_reset_evt has no effect on the timer.
- R8: A select-3 write with bit 0 set raises hold_busy for one cycle. At the end of that cycle hold_value takes pos_count and hold_busy clears by itself.
- R9: A rising edge on ext_flag[i] sets hold_busy only when control bit 5+i is set. A disabled flag, or a flag held high, triggers nothing.
- R10: If a hold request and a timer match capture in the same cycle, a single capture takes place and hold_value holds that cycle's pos_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 period, 2 count, 3 command |
| wr_data | input | CNT_W | Write data |
| pos_count | input | CNT_W | Live position count |
| idx_reset_evt | input | 1 | Index reset of the position counter occurred |
| ext_flag | input | NUM_EXT | External timer flags |
| timer_count | output | CNT_W | Current unit timer value |
| hold_value | output | CNT_W | Captured position count |
| hold_busy | output | 1 | Self-clearing hold request bit |
| event_flag | output | 1 | Sticky timer match flag |
| pos_reset_req | output | 1 | One-cycle request to clear the position counter |

## Verification
The bench targets several edge cases, and each one exposes a specific design error.

- **Clear and match in the same cycle.** A design where the clear wins loses the event.
- **Hold request and timer match on the same edge.** A design with two capture paths stores a stale or mixed value.
- **Write to the count while the timer is enabled.** A design that honours the write shows a jump in timer_count.
- **Index reset with follow-index off.** A design that ignores the option zeroes the timer.
- **External flag that is disabled, or held high.** A design with a wrong enable mask or level sensing captures when it should not, or captures repeatedly.

// File: rtl/utmr_pkg.sv
package utmr_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_CMD    = 2'd3
  } utmr_sel_e;

  // control word bit positions
  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_HOLD_BIT   = 1;
  localparam int CTRL_RST_BIT    = 2;
  localparam int CTRL_FOLLOW_BIT = 3;
  localparam int CTRL_RELOAD_BIT = 4;
  localparam int CTRL_EXT_LSB    = 5;

  // command word bit positions
  localparam int CMD_HOLD_BIT = 0;
  localparam int CMD_CLR_BIT  = 1;

endpackage

// File: rtl/utmr_counter.sv
module utmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             zero_req,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    match  = en && (cnt_q == period);
    cnt_ce = zero_req || en || ld_en;
    cnt_d  = cnt_q;
    if (zero_req) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = match ? '0 : cnt_q + 1'b1;
    end else if (ld_en) begin
      cnt_d = ld_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/utmr_rise.sv
module utmr_rise #(
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] flag_in,
  input  logic [NUM_EXT-1:0] flag_en,
  output logic [NUM_EXT-1:0] rise
);

  logic [NUM_EXT-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= flag_in;
    end
  end

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_edge
    assign rise[g] = flag_en[g] && flag_in[g] && !prev_q[g];
  end

endmodule

// File: rtl/utmr_hold.sv
module utmr_hold #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic             match_cap,
  input  logic [CNT_W-1:0] pos_count,
  output logic             busy,
  output logic             fire,
  output logic [CNT_W-1:0] hold_value
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] hold_q;

  always_comb begin
    busy_d = set_req;
    fire   = busy_q || match_cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (fire) begin
      hold_q <= pos_count;
    end
  end

  assign busy       = busy_q;
  assign hold_value = hold_q;

endmodule

// File: rtl/unit_timer_capture.sv
module unit_timer_capture
  import utmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [CNT_W-1:0]   pos_count,
  input  logic               idx_reset_evt,
  input  logic [NUM_EXT-1:0] ext_flag,
  output logic [CNT_W-1:0]   timer_count,
  output logic [CNT_W-1:0]   hold_value,
  output logic               hold_busy,
  output logic               event_flag,
  output logic               pos_reset_req
);

  localparam int CTRL_W = CTRL_EXT_LSB + NUM_EXT;

  logic [CTRL_W-1:0]  ctrl_q;
  logic [CNT_W-1:0]   period_q;
  logic               wr_ctrl, wr_period, wr_count, wr_cmd;
  logic               tmr_en, hold_on, reset_on, follow_idx, idx_reload;
  logic [NUM_EXT-1:0] ext_en, ext_rise;
  logic               idx_zero, match, hold_set, evt_clr, cap_fire;
  logic               evt_q, evt_d, rreq_q, rreq_d;

  always_comb begin
    wr_ctrl   = wr_en && (wr_sel == SEL_CTRL);
    wr_period = wr_en && (wr_sel == SEL_PERIOD);
    wr_count  = wr_en && (wr_sel == SEL_COUNT);
    wr_cmd    = wr_en && (wr_sel == SEL_CMD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wr_data[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
    end else if (wr_period) begin
      period_q <= wr_data;
    end
  end

  always_comb begin
    tmr_en     = ctrl_q[CTRL_EN_BIT];
    hold_on    = ctrl_q[CTRL_HOLD_BIT];
    reset_on   = ctrl_q[CTRL_RST_BIT];
    follow_idx = ctrl_q[CTRL_FOLLOW_BIT];
    idx_reload = ctrl_q[CTRL_RELOAD_BIT];
    ext_en     = ctrl_q[CTRL_EXT_LSB +: NUM_EXT];
    idx_zero   = follow_idx && idx_reload && idx_reset_evt;
    hold_set   = (wr_cmd && wr_data[CMD_HOLD_BIT]) || (|ext_rise);
    evt_clr    = wr_cmd && wr_data[CMD_CLR_BIT];
  end

  utmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tmr_en),
    .period   (period_q),
    .ld_en    (wr_count),
    .ld_val   (wr_data),
    .zero_req (idx_zero),
    .cnt      (timer_count),
    .match    (match)
  );

  utmr_rise #(.NUM_EXT(NUM_EXT)) u_rise (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag_in (ext_flag),
    .flag_en (ext_en),
    .rise    (ext_rise)
  );

  utmr_hold #(.CNT_W(CNT_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_req    (hold_set),
    .match_cap  (match && hold_on),
    .pos_count  (pos_count),
    .busy       (hold_busy),
    .fire       (cap_fire),
    .hold_value (hold_value)
  );

  // sticky flag: a set in the same cycle beats a clear
  always_comb begin
    evt_d  = match || (evt_q && !evt_clr);
    rreq_d = match && reset_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      rreq_q <= rreq_d;
    end
  end

  assign event_flag    = evt_q;
  assign pos_reset_req = rreq_q;

endmodule

// File: rtl/unit_timer_capture_chk.sv
module unit_timer_capture_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             match,
  input logic             reset_on,
  input logic             idx_zero,
  input logic             evt_clr,
  input logic             hold_set,
  input logic             cap_fire,
  input logic [CNT_W-1:0] pos_count,
  input logic [CNT_W-1:0] timer_count,
  input logic [CNT_W-1:0] hold_value,
  input logic             hold_busy,
  input logic             event_flag,
  input logic             pos_reset_req
);

  AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (timer_count == '0)); // R2

  AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> event_flag); // R3

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (event_flag && !evt_clr) |=> event_flag); // R3

  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (hold_value == $past(pos_count))); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> $stable(hold_value)); // R10

  AST_RREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (match && reset_on) |=> pos_reset_req); // R6

  AST_RREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(match && reset_on) |=> !pos_reset_req); // R6

  AST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    idx_zero |=> (timer_count == '0)); // R7

  AST_BUSY_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_busy && !hold_set) |=> !hold_busy); // R8

endmodule

bind unit_timer_capture unit_timer_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .match         (match),
  .reset_on      (reset_on),
  .idx_zero      (idx_zero),
  .evt_clr       (evt_clr),
  .hold_set      (hold_set),
  .cap_fire      (cap_fire),
  .pos_count     (pos_count),
  .timer_count   (timer_count),
  .hold_value    (hold_value),
  .hold_busy     (hold_busy),
  .event_flag    (event_flag),
  .pos_reset_req (pos_reset_req)
);

// File: tb/unit_timer_capture_test.sv
`timescale 1ns/1ps
module unit_timer_capture_test;

  localparam int CNT_W   = 32;
  localparam int NUM_EXT = 4;
  localparam int NV      = 17;

  logic               clk;
  logic               rst_n;
  logic               wr_en;
  logic [1:0]         wr_sel;
  logic [CNT_W-1:0]   wr_data;
  logic [CNT_W-1:0]   pos_count;
  logic               idx_reset_evt;
  logic [NUM_EXT-1:0] ext_flag;
  logic [CNT_W-1:0]   timer_count;
  logic [CNT_W-1:0]   hold_value;
  logic               hold_busy;
  logic               event_flag;
  logic               pos_reset_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  unit_timer_capture #(.CNT_W(CNT_W), .NUM_EXT(NUM_EXT)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pos_count(pos_count), .idx_reset_evt(idx_reset_evt), .ext_flag(ext_flag),
    .timer_count(timer_count), .hold_value(hold_value), .hold_busy(hold_busy),
    .event_flag(event_flag), .pos_reset_req(pos_reset_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // {wr_en, sel, data16, pos16, idx | exp_cnt8, exp_evt, exp_rreq, exp_busy, exp_hold16}
  localparam logic [62:0] VEC [NV] = '{
    {1'b1, 2'd1, 16'h0003, 16'h0000, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 16'h0000}, // period = 3
    {1'b1, 2'd2, 16'h0002, 16'h0000, 1'b0, 8'd2, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4 load while disabled
    {1'b1, 2'd0, 16'h0007, 16'h0011, 1'b0, 8'd2, 1'b0, 1'b0, 1'b0, 16'h0000}, // enable, hold+reset on match
    {1'b0, 2'd0, 16'h0000, 16'h0022, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b0, 2'd0, 16'h0000, 16'h0033, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 16'h0033}, // match: R2 R3 R5 R6
    {1'b0, 2'd0, 16'h0000, 16'h0044, 1'b0, 8'd1, 1'b1, 1'b0, 1'b0, 16'h0033},
    {1'b1, 2'd2, 16'h0050, 16'h0044, 1'b0, 8'd2, 1'b1, 1'b0, 1'b0, 16'h0033}, // R4 write ignored
    {1'b1, 2'd3, 16'h0002, 16'h0044, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0, 16'h0033}, // R3 clear
    {1'b1, 2'd3, 16'h0002, 16'h0055, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 16'h0055}, // R3 set beats clear
    {1'b0, 2'd0, 16'h0000, 16'h0055, 1'b1, 8'd1, 1'b1, 1'b0, 1'b0, 16'h0055}, // R7 follow off
    {1'b1, 2'd0, 16'h001F, 16'h0055, 1'b0, 8'd2, 1'b1, 1'b0, 1'b0, 16'h0055}, // follow + reload
    {1'b0, 2'd0, 16'h0000, 16'h0055, 1'b1, 8'd0, 1'b1, 1'b0, 1'b0, 16'h0055}, // R7 index zero
    {1'b1, 2'd3, 16'h0003, 16'h0066, 1'b0, 8'd1, 1'b0, 1'b0, 1'b1, 16'h0055}, // R8 request + clear
    {1'b0, 2'd0, 16'h0000, 16'h0077, 1'b0, 8'd2, 1'b0, 1'b0, 1'b0, 16'h0077}, // R8 capture
    {1'b1, 2'd3, 16'h0001, 16'h0088, 1'b0, 8'd3, 1'b0, 1'b0, 1'b1, 16'h0077},
    {1'b0, 2'd0, 16'h0000, 16'h0099, 1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 16'h0099}, // R10 joint capture
    {1'b0, 2'd0, 16'h0000, 16'h00AA, 1'b0, 8'd1, 1'b1, 1'b0, 1'b0, 16'h0099}
  };

  task automatic chk(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [62:0] v);
    wr_en         = v[62];
    wr_sel        = v[61:60];
    wr_data       = {16'h0000, v[59:44]};
    pos_count     = {16'h0000, v[43:28]};
    idx_reset_evt = v[27];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    pos_count = '0; idx_reset_evt = 1'b0; ext_flag = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 timer_count", timer_count, '0);
    chk("R1 hold_value", hold_value, '0);
    chk("R1 hold_busy", {31'd0, hold_busy}, '0);
    chk("R1 event_flag", {31'd0, event_flag}, '0);
    chk("R1 pos_reset_req", {31'd0, pos_reset_req}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    drive(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      chk("R2 timer_count", timer_count, {24'd0, VEC[i][26:19]});
      chk("R3 event_flag", {31'd0, event_flag}, {31'd0, VEC[i][18]});
      chk("R6 pos_reset_req", {31'd0, pos_reset_req}, {31'd0, VEC[i][17]});
      chk("R8 hold_busy", {31'd0, hold_busy}, {31'd0, VEC[i][16]});
      chk("R5 hold_value", hold_value, {16'd0, VEC[i][15:0]});
      if (i + 1 < NV) drive(VEC[i + 1]);
      else drive('0);
    end

    // R9: timer off, only external flag 0 enabled (control bit 5)
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0000_0020;
    @(negedge clk);
    wr_en = 1'b0; pos_count = 32'h1234;
    ext_flag = 4'b0010;  // disabled flag rises
    repeat (3) @(negedge clk);
    chk("R9 disabled flag busy", {31'd0, hold_busy}, '0);
    chk("R9 disabled flag hold", hold_value, 32'h99);
    ext_flag = 4'b0011;  // enabled flag rises
    @(negedge clk);
    chk("R9 enabled rise busy", {31'd0, hold_busy}, 32'd1);
    @(negedge clk);
    chk("R9 enabled rise hold", hold_value, 32'h1234);
    chk("R8 busy self clears", {31'd0, hold_busy}, '0);
    pos_count = 32'h4321;  // flag held high: no further capture
    repeat (3) @(negedge clk);
    chk("R9 level high hold", hold_value, 32'h1234);
    chk("R9 level high busy", {31'd0, hold_busy}, '0);

    finish_run();
  end

endmodule